// File: doc/BRIEF.md
# Card Status-Change Interrupt Router

This block watches the status lines of a removable-card socket (two card-detect lines, a READY line, a battery-warning line and a line that means battery-dead for memory cards or status-change for I/O cards). Each input is brought into the clock domain through a synchroniser and passed to an edge detector. Every edge the host has enabled sets a sticky pending bit. While any enabled pending bit is set, one interrupt level is driven. The output it appears on is chosen by a route select: a PCI interrupt, an SMI output, or one of the legacy IRQ lines.

The host reaches the block through a plain byte register port. Address 0 is the 8-bit configuration register, which holds the route select in bits 7:4 and four source enables in bits 3:0. Address 1 is the pending register, and reading it clears it. The port has no back-pressure. A write takes effect at the clock edge where `host_wr` is sampled high. A read returns data on `host_rdata` from the edge where `host_rd` is sampled, and that value is held until the next read. Route select 0 depends on two external controls. With the diagnostic bit set, the interrupt always goes to the PCI output. With it clear, the interrupt goes to the PCI output only when the PCI-routing enable is high. Two resets exist, and while power-management events are enabled the configuration survives the PCI reset.

Top module: `csc_irq_router`

## Requirements
- R1: After any reset the configuration reads 00h, the pending register reads 0 and every interrupt output is low.
- R2: A write to address 0 stores all 8 bits. A read of address 0 returns them on `host_rdata` after the edge that samples `host_rd`. A write to address 1 has no effect.
- R3: With configuration bit 3 set, any change of `cd1` or `cd2`, in either direction, sets pending bit 3.
- R4: With configuration bit 2 set, a low-to-high transition of `card_ready` sets pending bit 2. A high-to-low transition sets nothing.
- R5: With configuration bit 1 set, a rise of `bat_warn` sets pending bit 1. With bit 0 set, a rise of `bat_dead` sets pending bit 0.
- R6: An event whose enable bit is 0 sets no pending bit and drives no output.
- R7: Pending bits stay set until the host reads address 1. That read returns them in bits 3:0 (bits 7:4 read 0) and clears them. An event detected in the same cycle as the read stays pending.
- R8: The interrupt is active while (pending AND enables) is nonzero. Select 1 drives `irq_out[1]`, select 2 drives `int_smi`, and selects 3 to 15 drive `irq_out[3]` to `irq_out[15]`. `irq_out[0]` and `irq_out[2]` are never driven. At most one output is high. A change of select moves the active level immediately after the write edge.
- R9: With select 0 and `diag_pci`=1, the interrupt drives `int_pci` whatever `pci_route_en` is. With select 0 and `diag_pci`=0, it drives `int_pci` only if `pci_route_en`=1, and no legacy line is driven in either case.
- R10: `gbl_rst_n` low clears the configuration. `pci_rst_n` low clears it only while `pme_en`=0. Either reset clears the pending bits and the synchronisers, and writes are ignored while either reset is low.
- R11: An input change set up before clock edge k is visible as a pending bit and as an interrupt output just after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| gbl_rst_n | input | 1 | Global reset, active low, synchronous |
| pci_rst_n | input | 1 | PCI reset, active low, synchronous |
| pme_en | input | 1 | Power-management events enabled; shields configuration from PCI reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_sel | input | 1 | Register select: 0 configuration, 1 pending |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, registered |
| diag_pci | input | 1 | Diagnostic bit: select 0 forces PCI routing |
| pci_route_en | input | 1 | PCI routing enable used when select is 0 and diag_pci is 0 |
| cd1 | input | 1 | Card-detect line 1, asynchronous |
| cd2 | input | 1 | Card-detect line 2, asynchronous |
| card_ready | input | 1 | Card READY line, asynchronous |
| bat_warn | input | 1 | Battery-warning line, asynchronous |
| bat_dead | input | 1 | Battery-dead / status-change line, asynchronous |
| int_pci | output | 1 | PCI interrupt level |
| int_smi | output | 1 | SMI level |
| irq_out | output | 16 | Legacy IRQ levels, bit n is IRQn |

## Verification
The properties assume that `gbl_rst_n` is applied before any check matters, because they are disabled while it is low. They also assume that `host_rd` and `host_wr` are never high together with a reset. The stimulus holds every socket input low through each reset, so the cleared synchronisers start out matching the pins. It changes those inputs only at falling clock edges and leaves at least three cycles between a change and the read that is meant to observe it.

// File: rtl/csc_pkg.sv
`timescale 1ns/1ps
package csc_pkg;
  localparam int N_IRQ  = 16;
  localparam int SEL_W  = $clog2(N_IRQ);
  localparam int N_SRC  = 4;
  localparam int N_PIN  = 5;
  localparam int CFG_W  = SEL_W + N_SRC;
  // pin vector positions
  localparam int PIN_CD1 = 0;
  localparam int PIN_CD2 = 1;
  localparam int PIN_RDY = 2;
  localparam int PIN_BW  = 3;
  localparam int PIN_BD  = 4;
  // source / enable bit positions
  localparam int SRC_BD  = 0;
  localparam int SRC_BW  = 1;
  localparam int SRC_RDY = 2;
  localparam int SRC_CD  = 3;
  localparam logic [SEL_W-1:0] SEL_PCI = '0;
  localparam logic [SEL_W-1:0] SEL_SMI = SEL_W'(2);
endpackage

// File: rtl/csc_sync_edge.sv
`timescale 1ns/1ps
module csc_sync_edge #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur,
  output logic [W-1:0] prv
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (clr) stg[0] <= '0;
    else     stg[0] <= din;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (clr) stg[i] <= '0;
      else     stg[i] <= stg[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (clr) prv <= '0;
    else     prv <= stg[STAGES-1];
  end

  assign cur = stg[STAGES-1];
endmodule

// File: rtl/csc_pending.sv
`timescale 1ns/1ps
module csc_pending
  import csc_pkg::*;
(
  input  logic             clk,
  input  logic             clr,
  input  logic [N_PIN-1:0] cur,
  input  logic [N_PIN-1:0] prv,
  input  logic [N_SRC-1:0] en,
  input  logic             rd_clr,
  output logic [N_SRC-1:0] pend,
  output logic [N_SRC-1:0] hit
);
  logic [N_SRC-1:0] raw;

  always_comb begin
    raw          = '0;
    raw[SRC_CD]  = (cur[PIN_CD1] ^ prv[PIN_CD1]) | (cur[PIN_CD2] ^ prv[PIN_CD2]);
    raw[SRC_RDY] = cur[PIN_RDY] & ~prv[PIN_RDY];
    raw[SRC_BW]  = cur[PIN_BW]  & ~prv[PIN_BW];
    raw[SRC_BD]  = cur[PIN_BD]  & ~prv[PIN_BD];
  end

  assign hit = raw & en;

  always_ff @(posedge clk) begin
    if (clr)         pend <= '0;
    else if (rd_clr) pend <= hit;
    else             pend <= pend | hit;
  end
endmodule

// File: rtl/csc_route.sv
`timescale 1ns/1ps
module csc_route
  import csc_pkg::*;
#(
  parameter int LINES = N_IRQ
) (
  input  logic             act,
  input  logic [SEL_W-1:0] sel,
  input  logic             diag,
  input  logic             pci_en,
  output logic             int_pci,
  output logic             int_smi,
  output logic [LINES-1:0] irq
);
  assign int_pci = act && (sel == SEL_PCI) && (diag || pci_en);
  assign int_smi = act && (sel == SEL_SMI);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    if (i == 0 || i == 2) begin : g_none
      assign irq[i] = 1'b0;
    end else begin : g_irq
      assign irq[i] = act && (sel == SEL_W'(i));
    end
  end
endmodule

// File: rtl/csc_irq_router.sv
`timescale 1ns/1ps
module csc_irq_router
  import csc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             gbl_rst_n,
  input  logic             pci_rst_n,
  input  logic             pme_en,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic             host_sel,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  input  logic             diag_pci,
  input  logic             pci_route_en,
  input  logic             cd1,
  input  logic             cd2,
  input  logic             card_ready,
  input  logic             bat_warn,
  input  logic             bat_dead,
  output logic             int_pci,
  output logic             int_smi,
  output logic [N_IRQ-1:0] irq_out
);
  logic             rst_all, cfg_clr;
  logic [CFG_W-1:0] cfg_q;
  logic [N_PIN-1:0] pins, cur, prv;
  logic [N_SRC-1:0] pend_q, hit;
  logic             act;

  assign rst_all = !gbl_rst_n || !pci_rst_n;
  assign cfg_clr = !gbl_rst_n || (!pci_rst_n && !pme_en);

  always_ff @(posedge clk) begin
    if (cfg_clr)                               cfg_q <= '0;
    else if (!rst_all && host_wr && !host_sel) cfg_q <= host_wdata[CFG_W-1:0];
  end

  assign pins = {bat_dead, bat_warn, card_ready, cd2, cd1};

  csc_sync_edge #(.W(N_PIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .clr(rst_all), .din(pins), .cur(cur), .prv(prv)
  );

  csc_pending u_pend (
    .clk(clk), .clr(rst_all), .cur(cur), .prv(prv), .en(cfg_q[N_SRC-1:0]),
    .rd_clr(host_rd && host_sel), .pend(pend_q), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (rst_all)      host_rdata <= '0;
    else if (host_rd) host_rdata <= host_sel ? 8'({pend_q}) : 8'(cfg_q);
  end

  assign act = |(pend_q & cfg_q[N_SRC-1:0]);

  csc_route #(.LINES(N_IRQ)) u_route (
    .act(act), .sel(cfg_q[CFG_W-1:N_SRC]), .diag(diag_pci), .pci_en(pci_route_en),
    .int_pci(int_pci), .int_smi(int_smi), .irq(irq_out)
  );
endmodule

// File: rtl/csc_irq_router_chk.sv
`timescale 1ns/1ps
module csc_irq_router_chk
  import csc_pkg::*;
(
  input logic             clk,
  input logic             gbl_rst_n,
  input logic             pci_rst_n,
  input logic             pme_en,
  input logic             host_rd,
  input logic             host_sel,
  input logic             diag_pci,
  input logic             pci_route_en,
  input logic             int_pci,
  input logic             int_smi,
  input logic [N_IRQ-1:0] irq_out,
  input logic [CFG_W-1:0] cfg_q,
  input logic [N_SRC-1:0] pend_q,
  input logic [N_SRC-1:0] hit
);
  logic active;
  assign active = |(pend_q & cfg_q[N_SRC-1:0]);

  p_one_output_r8: assert property (@(posedge clk) disable iff (!gbl_rst_n)
    $onehot0({int_pci, int_smi, irq_out}));

  p_unused_lines_r8: assert property (@(posedge clk) disable iff (!gbl_rst_n)
    !irq_out[0] && !irq_out[2]);

  p_level_r8: assert property (@(posedge clk) disable iff (!gbl_rst_n)
    !active |-> ($countones({int_pci, int_smi, irq_out}) == 0));

  p_diag_force_r9: assert property (@(posedge clk) disable iff (!gbl_rst_n)
    (active && cfg_q[CFG_W-1:N_SRC] == '0 && diag_pci) |-> int_pci);

  p_no_pci_r9: assert property (@(posedge clk) disable iff (!gbl_rst_n)
    (cfg_q[CFG_W-1:N_SRC] == '0 && !diag_pci && !pci_route_en) |-> !int_pci);

  p_sticky_r7: assert property (@(posedge clk) disable iff (!gbl_rst_n)
    (pci_rst_n && !(host_rd && host_sel)) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  p_read_clears_r7: assert property (@(posedge clk) disable iff (!gbl_rst_n)
    (pci_rst_n && host_rd && host_sel) |=> (pend_q == $past(hit)));

  p_pme_keeps_cfg_r10: assert property (@(posedge clk) disable iff (!gbl_rst_n)
    (pme_en && !pci_rst_n) |=> $stable(cfg_q));
endmodule

bind csc_irq_router csc_irq_router_chk u_chk (.*);

// File: tb/csc_irq_router_test.sv
`timescale 1ns/1ps
module csc_irq_router_test;
  logic clk = 0;
  logic gbl_rst_n = 0, pci_rst_n = 0, pme_en = 0;
  logic host_wr = 0, host_rd = 0, host_sel = 0;
  logic [7:0] host_wdata = 0;
  logic [7:0] host_rdata;
  logic diag_pci = 0, pci_route_en = 0;
  logic cd1 = 0, cd2 = 0, card_ready = 0, bat_warn = 0, bat_dead = 0;
  logic int_pci, int_smi;
  logic [15:0] irq_out;

  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  csc_irq_router uut (.*);

  // behavioural reference
  logic [7:0] m_cfg = 0, m_rd = 0;
  logic [3:0] m_pend = 0, m_ev;
  logic [4:0] h1 = 0, h2 = 0, h3 = 0, pinv;
  logic m_rst, m_cclr;

  always @(posedge clk) begin
    pinv   = {bat_dead, bat_warn, card_ready, cd2, cd1};
    m_rst  = !gbl_rst_n || !pci_rst_n;
    m_cclr = !gbl_rst_n || (!pci_rst_n && !pme_en);
    m_ev[3] = (h2[0] != h3[0]) || (h2[1] != h3[1]);
    m_ev[2] = h2[2] && !h3[2];
    m_ev[1] = h2[3] && !h3[3];
    m_ev[0] = h2[4] && !h3[4];
    if (m_rst) begin
      h1 = 0; h2 = 0; h3 = 0; m_pend = 0; m_rd = 0;
    end else begin
      if (host_rd) m_rd = host_sel ? {4'b0, m_pend} : m_cfg;
      m_pend = ((host_rd && host_sel) ? 4'b0 : m_pend) | (m_ev & m_cfg[3:0]);
      h3 = h2; h2 = h1; h1 = pinv;
    end
    if (m_cclr) m_cfg = 0;
    else if (!m_rst && host_wr && !host_sel) m_cfg = host_wdata;
  end

  function automatic logic [17:0] model_out();
    logic [17:0] o = 0;   // {pci, smi, irq[15:0]}
    int s = m_cfg[7:4];
    if ((m_pend & m_cfg[3:0]) != 0) begin
      if (s == 0) o[17] = diag_pci || pci_route_en;
      else if (s == 2) o[16] = 1;
      else o[s] = 1;
    end
    return o;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    logic [17:0] e;
    e = model_out();
    chk("R8", {16'b0, int_smi, irq_out}, {16'b0, e[16:0]});
    chk("R9", {31'b0, int_pci}, {31'b0, e[17]});
    chk("R7", {24'b0, host_rdata}, {24'b0, m_rd});
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_wr = 0; host_sel = 0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] d);
    @(negedge clk);
    host_rd = 1; host_sel = sel;
    @(negedge clk);
    d = host_rdata;
    host_rd = 0; host_sel = 0;
  endtask

  initial begin : watchdog
    #1_000_000;
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    tick(3);
    gbl_rst_n = 1; pci_rst_n = 1;
    tick(1);
    rd(0, v); chk("R1 cfg", {24'b0, v}, 32'h00);
    rd(1, v); chk("R1 pend", {24'b0, v}, 32'h00);
    chk("R1 outs", {14'b0, int_pci, int_smi, irq_out}, 0);

    wr(0, 8'hA5); rd(0, v); chk("R2", {24'b0, v}, 32'hA5);
    wr(0, 8'h5A); rd(0, v); chk("R2", {24'b0, v}, 32'h5A);
    wr(1, 8'hFF); rd(0, v); chk("R2 pend write ignored", {24'b0, v}, 32'h5A);
    rd(1, v); chk("R2 pend write ignored", {24'b0, v}, 32'h00);

    // card detect, sel 3, all enabled
    wr(0, 8'h3F);
    @(negedge clk); cd1 = 1;
    tick(2); chk("R11 before", {31'b0, irq_out[3]}, 0);
    tick(1); chk("R11 after", {31'b0, irq_out[3]}, 1);
    rd(1, v); chk("R3 rise", {24'b0, v}, 32'h08);
    tick(1); chk("R7 cleared", {31'b0, irq_out[3]}, 0);
    cd1 = 0; tick(4); rd(1, v); chk("R3 fall", {24'b0, v}, 32'h08);
    cd2 = 1; tick(4); rd(1, v); chk("R3 cd2", {24'b0, v}, 32'h08);
    cd2 = 0; tick(4); rd(1, v);

    card_ready = 1; tick(4); rd(1, v); chk("R4 rise", {24'b0, v}, 32'h04);
    card_ready = 0; tick(4); rd(1, v); chk("R4 fall", {24'b0, v}, 32'h00);
    bat_warn = 1; tick(4); rd(1, v); chk("R5 warn", {24'b0, v}, 32'h02);
    bat_dead = 1; tick(4); rd(1, v); chk("R5 dead", {24'b0, v}, 32'h01);
    bat_warn = 0; bat_dead = 0; tick(4); rd(1, v); chk("R5 falls", {24'b0, v}, 32'h00);

    // sticky: two sources accumulate
    cd1 = 1; card_ready = 1; tick(8);
    chk("R7 sticky", {31'b0, irq_out[3]}, 1);
    rd(1, v); chk("R7 both", {24'b0, v}, 32'h0C);
    cd1 = 0; card_ready = 0; tick(4); rd(1, v);

    // disabled sources
    wr(0, 8'h30);
    cd1 = 1; card_ready = 1; bat_warn = 1; bat_dead = 1; tick(5);
    chk("R6 no irq", {15'b0, int_pci, int_smi, irq_out}, 0);
    rd(1, v); chk("R6 no pend", {24'b0, v}, 32'h00);
    cd1 = 0; card_ready = 0; bat_warn = 0; bat_dead = 0; tick(4);

    // route sweep
    for (int s = 1; s < 16; s++) begin
      wr(0, {s[3:0], 4'h8});
      cd1 = ~cd1; tick(4);
      if (s == 2) chk("R8 smi", {15'b0, int_pci, int_smi, irq_out}, 32'h10000);
      else        chk("R8 irq", {15'b0, int_pci, int_smi, irq_out}, 32'h1 << s);
      rd(1, v); tick(1);
      chk("R8 idle", {15'b0, int_pci, int_smi, irq_out}, 0);
    end

    // reroute while pending
    wr(0, 8'h58); cd1 = ~cd1; tick(4);
    chk("R8 pre", {16'b0, irq_out}, 32'h0020);
    wr(0, 8'hC8);
    chk("R8 moved", {16'b0, irq_out}, 32'h1000);

    // select 0
    wr(0, 8'h08);
    diag_pci = 0; pci_route_en = 0; tick(1);
    chk("R9 none", {15'b0, int_pci, int_smi, irq_out}, 0);
    pci_route_en = 1; tick(1); chk("R9 en", {31'b0, int_pci}, 1);
    diag_pci = 1; pci_route_en = 0; tick(1); chk("R9 diag", {31'b0, int_pci}, 1);
    diag_pci = 1; pci_route_en = 1; tick(1); chk("R9 both", {31'b0, int_pci}, 1);
    chk("R9 no legacy", {16'b0, irq_out}, 0);
    rd(1, v); diag_pci = 0; pci_route_en = 0;
    cd1 = 0; tick(4); rd(1, v);

    // reset domains
    wr(0, 8'h3F); cd2 = 1; tick(4); cd2 = 0; tick(1);
    pme_en = 1; pci_rst_n = 0; tick(2); pci_rst_n = 1; tick(1);
    chk("R10 outs", {15'b0, int_pci, int_smi, irq_out}, 0);
    rd(0, v); chk("R10 pme keeps", {24'b0, v}, 32'h3F);
    rd(1, v); chk("R10 pend cleared", {24'b0, v}, 32'h00);
    pme_en = 0; pci_rst_n = 0; tick(2); pci_rst_n = 1; tick(1);
    rd(0, v); chk("R10 pci clears", {24'b0, v}, 32'h00);
    wr(0, 8'h3F); pme_en = 1; gbl_rst_n = 0; tick(2); gbl_rst_n = 1; tick(1);
    rd(0, v); chk("R1 gbl clears", {24'b0, v}, 32'h00);
    pme_en = 0;
    tick(3);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule